// File: doc/BRIEF.md
# Low-First Pulse-Width Modulator

This block drives one pulse-width modulated output from a free-running counter that is advanced by a programmable prescaler. Each output period is a number of prescaled ticks set by a cycle register. The period opens with a low phase whose length comes from a low-time register, and the output is high for the rest of the period. If the low time is larger than the cycle value, the output stays low for the whole period. A polarity bit inverts the waveform, so the same settings can produce a high-first signal.

Software reaches the block through a single-cycle write port with three addresses:
- Address 0 is control: bit 0 enables counting, bit 1 inverts the output, and bits 3:2 select the prescaler.
- Address 1 is the cycle register.
- Address 2 is the low-time register.

Writes to address 3 have no effect. The cycle register can only change while counting is stopped. The low time can be written at any time; a new value is held back until the period boundary so that no period mixes two settings.

Top module: `lowfirst_pwm`

## Requirements
- R1: A synchronous active-low reset clears the control, cycle and low-time registers and the counter, and drives pwm_out to 0. Setting only the enable bit (address 0, bit 0) after reset then gives a constant high output.
- R2: While enabled, one output period lasts (CYC+1)·N clock cycles, where N is the division ratio chosen by the prescaler.
- R3: Each period starts with LOW·N cycles at the low-phase level, followed by (CYC+1−LOW)·N cycles at the opposite level. This includes LOW equal to CYC, which leaves one tick high.
- R4: When LOW is greater than CYC, the output stays at the low-phase level for the whole period. This also covers CYC=0 with LOW≥1.
- R5: When LOW is 0, the output stays at the high-phase level.
- R6: A write to the cycle register (address 1) while the enable bit is 1 is discarded. It is not applied later when counting stops.
- R7: The invert bit (address 0, bit 1) swaps both output levels. With the bit set, each period starts high.
- R8: The prescaler field (address 0, bits 3:2) selects the division ratio: 0 gives 1, 1 gives 16, 2 gives 256 and 3 gives 2048.
- R9: Clearing the enable bit drives pwm_out to the value of the invert bit. Setting it again restarts the count at 0 with a complete low phase.
- R10: A low-time write (address 2) made while counting first takes effect in the period that follows the next wrap from CYC to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Register select: 0 control, 1 cycle, 2 low time |
| wr_data | input | CNT_W (24) | Write data; control uses bits 3:0 |
| pwm_out | output | 1 | Modulated output |

## Verification
Two situations are hard to reach from the ports.

The first is a low-time update that must land in one particular period. The bench writes the new value a fixed number of cycles after the enable edge, so the write falls in the middle of the first period. The expected run lengths then show the old low time for one period and the new one afterwards.

The second is a cycle write that arrives while the counter is running. The bench first shows that the old period continues. It then stops and restarts the counter without writing the cycle register again, which shows the discarded value was never applied later.

The slowest prescaler setting is paired with a cycle value of 1, so that divide-by-2048 can be observed in a few thousand clocks.

// File: rtl/lfpwm_pkg.sv
package lfpwm_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CYC  = 2'd1,
    ADDR_LOW  = 2'd2,
    ADDR_RSVD = 2'd3
  } addr_e;

  // Bit 0 enable, bit 1 invert, bits 3:2 prescaler select
  typedef struct packed {
    logic [1:0] psel;
    logic       inv;
    logic       en;
  } ctrl_t;

  // log2 of the division ratio for each prescaler select code
  function automatic int unsigned div_shift(logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 11;
    endcase
  endfunction

  // Terminal value of the prescaler counter (ratio minus one)
  function automatic logic [31:0] pre_limit(logic [1:0] sel);
    return (32'd1 << div_shift(sel)) - 32'd1;
  endfunction

  // Output level from run state, phase and polarity
  function automatic logic out_level(logic en, logic high_phase, logic inv);
    return (en & high_phase) ^ inv;
  endfunction

endpackage

// File: rtl/lfpwm_regs.sv
module lfpwm_regs
  import lfpwm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  output ctrl_t                ctrl_q,
  output logic [CNT_W-1:0]     cyc_q,
  output logic [CNT_W-1:0]     low_q
);

  localparam int CTRL_W = $bits(ctrl_t);

  logic ctrl_hit, cyc_hit, low_hit, cyc_ok;

  assign ctrl_hit = wr_en && (addr_e'(wr_addr) == ADDR_CTRL);
  assign cyc_hit  = wr_en && (addr_e'(wr_addr) == ADDR_CYC);
  assign low_hit  = wr_en && (addr_e'(wr_addr) == ADDR_LOW);
  // The cycle length is locked while the counter runs
  assign cyc_ok   = cyc_hit && !ctrl_q.en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cyc_q  <= '0;
      low_q  <= '0;
    end else begin
      if (ctrl_hit) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (cyc_ok)   cyc_q  <= wr_data;
      if (low_hit)  low_q  <= wr_data;
    end
  end

endmodule

// File: rtl/lfpwm_prescaler.sv
module lfpwm_prescaler
  import lfpwm_pkg::*;
#(
  parameter int PRE_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] psel,
  output logic       tick
);

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(pre_limit(psel));
  // ">=" keeps the divider safe if the ratio is lowered mid-count
  assign tick  = run && (div_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/lfpwm_core.sv
module lfpwm_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] low_req,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] low_act_q,
  output logic             wrap,
  output logic             high_phase
);

  assign wrap       = run && tick && (cnt_q == cyc);
  assign high_phase = (cnt_q >= low_act_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Low time in use: follows the register while stopped, reloads at each wrap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_act_q <= '0;
    end else if (!run || wrap) begin
      low_act_q <= low_req;
    end
  end

endmodule

// File: rtl/lowfirst_pwm.sv
module lowfirst_pwm
  import lfpwm_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] low_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_act_q;
  logic             en_q;
  logic             inv_q;
  logic             tick;
  logic             wrap;
  logic             high_phase;

  assign en_q  = ctrl_q.en;
  assign inv_q = ctrl_q.inv;

  lfpwm_regs #(.CNT_W(CNT_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .cyc_q   (cyc_q),
    .low_q   (low_q)
  );

  lfpwm_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .psel  (ctrl_q.psel),
    .tick  (tick)
  );

  lfpwm_core #(.CNT_W(CNT_W)) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (en_q),
    .tick       (tick),
    .cyc        (cyc_q),
    .low_req    (low_q),
    .cnt_q      (cnt_q),
    .low_act_q  (low_act_q),
    .wrap       (wrap),
    .high_phase (high_phase)
  );

  assign pwm_out = out_level(en_q, high_phase, inv_q);

endmodule

// File: rtl/lfpwm_chk.sv
module lfpwm_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             inv_q,
  input logic             tick,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cyc_q,
  input logic [CNT_W-1:0] low_act_q,
  input logic             pwm_out
);

  a_r6_cyc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(cyc_q));

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (cnt_q <= cyc_q));

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (cnt_q == '0));

  a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pwm_out == inv_q));

  a_r4_full_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && (low_act_q > cyc_q)) |-> (pwm_out == inv_q));

  a_r10_low_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wrap) |=> $stable(low_act_q));

  a_r8_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en_q);

endmodule

bind lowfirst_pwm lfpwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .inv_q     (inv_q),
  .tick      (tick),
  .wrap      (wrap),
  .cnt_q     (cnt_q),
  .cyc_q     (cyc_q),
  .low_act_q (low_act_q),
  .pwm_out   (pwm_out)
);

// File: tb/lowfirst_pwm_tb_top.sv
`timescale 1ns/1ps
module lowfirst_pwm_tb_top;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         pwm_out;

  always #4 clk = ~clk;

  lowfirst_pwm dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out)
  );

  typedef struct {
    bit    lvl;
    int    len;
    string req;
  } seg_t;

  seg_t  exp_q[$];
  seg_t  mon_s;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    sync_req = 1'b0;
  bit    tracking = 1'b0;
  bit    cur_lvl = 1'b0;
  int    cur_len = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: measures run lengths and compares them with the queue
  always @(negedge clk) begin
    if (sync_req) begin
      tracking = 1'b1;
      cur_lvl  = pwm_out;
      cur_len  = 1;
      sync_req = 1'b0;
    end else if (tracking) begin
      if (pwm_out == cur_lvl) begin
        cur_len++;
      end else begin
        if (exp_q.size() > 0) begin
          mon_s = exp_q.pop_front();
          n_chk++;
          if (mon_s.lvl != cur_lvl || mon_s.len != cur_len) begin
            n_bad++;
            $display("FAIL %s run: actual level=%0d len=%0d expected level=%0d len=%0d",
                     mon_s.req, cur_lvl, cur_len, mon_s.lvl, mon_s.len);
          end
        end
        cur_lvl = pwm_out;
        cur_len = 1;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [W-1:0] ctrlw(bit en, bit inv, logic [1:0] ps);
    return W'({ps, inv, en});
  endfunction

  // Enable write; the monitor restarts at the first cycle with counting on
  task automatic start(bit inv, logic [1:0] ps);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctrlw(1'b1, inv, ps);
    #1 sync_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stop(bit inv);
    wr(2'd0, ctrlw(1'b0, inv, 2'd0));
    repeat (3) @(negedge clk);
  endtask

  task automatic push_periods(bit first, int lo, int hi, int n, string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{first, lo, req});
      exp_q.push_back('{~first, hi, req});
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic hold_check(bit lvl, int cycles, string req, string what);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out != lvl) bad++;
    end
    check(bad == 0, req, what, bad, 0);
  endtask

  task automatic cfg(int cyc, int low);
    wr(2'd1, W'(cyc));
    wr(2'd2, W'(low));
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(pwm_out == 1'b0, "R1", "reset level", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: cleared registers -> CYC=0, LOW=0 -> constant high once enabled
    start(1'b0, 2'd0);
    hold_check(1'b1, 20, "R1", "cleared regs high");
    stop(1'b0);

    // R2 R3: basic low-first waveform, divide by 1
    cfg(9, 3);
    push_periods(1'b0, 3, 7, 3, "R2,R3");
    start(1'b0, 2'd0);
    drain();
    stop(1'b0);

    // R7: inverted waveform starts high
    cfg(4, 1);
    push_periods(1'b1, 1, 4, 3, "R7");
    start(1'b1, 2'd0);
    drain();
    stop(1'b1);
    check(pwm_out == 1'b1, "R9", "idle level inverted", pwm_out, 1);
    stop(1'b0);
    check(pwm_out == 1'b0, "R9", "idle level plain", pwm_out, 0);

    // R3: LOW equal to CYC leaves one high tick
    cfg(5, 5);
    push_periods(1'b0, 5, 1, 3, "R3");
    start(1'b0, 2'd0);
    drain();
    stop(1'b0);

    // R4: LOW greater than CYC
    cfg(3, 7);
    start(1'b0, 2'd0);
    hold_check(1'b0, 40, "R4", "full low");
    stop(1'b0);

    // R4: CYC=0 with LOW=1
    cfg(0, 1);
    start(1'b0, 2'd0);
    hold_check(1'b0, 20, "R4", "cyc0 full low");
    stop(1'b0);

    // R5: LOW=0 gives constant high
    cfg(3, 0);
    start(1'b0, 2'd0);
    hold_check(1'b1, 40, "R5", "low0 high");
    stop(1'b0);

    // R8: prescaler ratios 16, 256, 2048
    cfg(3, 1);
    push_periods(1'b0, 16, 48, 2, "R8");
    start(1'b0, 2'd1);
    drain();
    stop(1'b0);
    cfg(2, 1);
    push_periods(1'b0, 256, 512, 1, "R8");
    start(1'b0, 2'd2);
    drain();
    stop(1'b0);
    cfg(1, 1);
    push_periods(1'b0, 2048, 2048, 1, "R8");
    start(1'b0, 2'd3);
    drain();
    stop(1'b0);

    // R6: cycle write while running is dropped, not deferred
    cfg(5, 2);
    push_periods(1'b0, 2, 4, 3, "R6");
    start(1'b0, 2'd0);
    wr(2'd1, W'(9));
    drain();
    stop(1'b0);
    push_periods(1'b0, 2, 4, 2, "R6");
    start(1'b0, 2'd0);
    drain();
    stop(1'b0);

    // R10: low-time write lands after the next wrap
    cfg(7, 2);
    exp_q.push_back('{1'b0, 2, "R10"});
    exp_q.push_back('{1'b1, 6, "R10"});
    push_periods(1'b0, 5, 3, 2, "R10");
    start(1'b0, 2'd0);
    wr(2'd2, W'(5));
    drain();
    stop(1'b0);

    // R9: stop in the high phase, restart with a full low phase
    cfg(5, 3);
    start(1'b0, 2'd0);
    repeat (4) @(negedge clk);
    stop(1'b0);
    hold_check(1'b0, 5, "R9", "stopped mid-period");
    push_periods(1'b0, 3, 3, 2, "R9");
    start(1'b0, 2'd0);
    drain();

    // R1: reset while running clears everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(pwm_out == 1'b0, "R1", "reset mid-run", pwm_out, 0);
    rst_n = 1'b1;
    start(1'b0, 2'd0);
    hold_check(1'b1, 20, "R1", "regs cleared by reset");
    stop(1'b0);

    summary();
    $finish;
  end

endmodule